// File: doc/BRIEF.md
# UART Line Status and Error Tracker

This block keeps the line status of a UART's receive and transmit paths and presents it as one 8-bit status word to a host bus. The receive path has a queue of up to `RX_DEPTH` characters. Each stored character carries three error tags: parity, framing and break. The status word shows only the tags of the character at the head of the queue. A separate aggregate bit stays set while any queued character carries a tag. The transmit path has a queue of up to `TX_DEPTH` bytes, and the status word reports when that queue has drained and when the shifter has also gone idle.

The serial shifters and baud timing sit outside the block. A one-cycle `rx_stb` delivers each received character together with its raw error flags. The transmit shifter takes the head byte with `tx_take` and reports its own activity on `tx_busy`. When `fifo_mode` is low, both queues behave as single-entry holding registers. Two interrupt requests are produced: a line-error request and a holding-empty request.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status word is 8'h00 and both interrupt requests are low.
- R2: Bit 0 is 1 exactly while at least one character is queued. Characters leave the queue on `rx_pop` in arrival order, and `rx_head` shows the oldest one.
- R3: Bits 2 (parity), 3 (framing) and 4 (break) show the tags of the head character. The parity tag is recorded only if `parity_en` was high when the character arrived.
- R4: A status read (`lsr_rd`) hides the parity and framing bits of the current head until that character leaves. The break bit is not cleared by a read.
- R5: With `fifo_mode` high, a character that arrives while `RX_DEPTH` characters are queued sets bit 1 and is discarded, leaving the queue unchanged. Bit 1 clears after a status read.
- R6: With `fifo_mode` low, a second character that arrives before the first is popped sets bit 1. The first character is kept.
- R7: Bit 7 is 1 while any queued character carries a tag, and it falls once all such characters have been popped.
- R8: Flushing the receive queue (`rx_flush`) while bit 7 is 1 locks bit 7 at 1 until the next reset.
- R9: For the first character stored after reset, bit 7 reflects its errors but bits 2 to 4 stay 0 for it.
- R10: Bit 5 is set only when the shifter takes the last queued transmit byte. A transmit write clears it. Neither reset nor `tx_flush` sets it. Bytes leave in write order on `tx_head`.
- R11: Bit 6 is 1 only when bit 5 is 1 and `tx_busy` is low.
- R12: `irq_ls` is high while `lsi_en` is high and any of bits 1 to 4 is 1.
- R13: `irq_thre` goes high when bit 5 rises while `thre_en` is high. It drops on a status read, on a transmit write, or when `thre_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1: queued operation; 0: single holding entry |
| parity_en | input | 1 | Parity checking enabled |
| lsi_en | input | 1 | Line-error interrupt enable |
| thre_en | input | 1 | Holding-empty interrupt enable |
| rx_stb | input | 1 | A received character is valid this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the received character |
| rx_ferr | input | 1 | Framing error flag of the received character |
| rx_brk | input | 1 | Break flag of the received character |
| rx_pop | input | 1 | Host reads the head character |
| rx_flush | input | 1 | Empty the receive queue |
| rx_head | output | 8 | Head character of the receive queue |
| lsr_rd | input | 1 | Host reads the status word this cycle |
| lsr | output | 8 | Line status word |
| tx_wr | input | 1 | Host writes a transmit byte |
| tx_data | input | 8 | Transmit byte |
| tx_flush | input | 1 | Empty the transmit queue |
| tx_take | input | 1 | Shifter takes the head transmit byte |
| tx_busy | input | 1 | Transmit shift register is occupied |
| tx_avail | output | 1 | Transmit queue holds a byte |
| tx_head | output | 8 | Head byte of the transmit queue |
| irq_ls | output | 1 | Line-error interrupt request |
| irq_thre | output | 1 | Holding-empty interrupt request |

## Verification
The hardest state to reach is the locked aggregate-error bit, because it needs a tagged character to be queued and the queue to be flushed, and a correct lock can only be told apart from a stale error counter by later traffic. The bench first pushes and pops one clean character so that the first-character rule no longer applies. It then queues a tagged character, flushes, and passes clean characters through the queue to show that bit 7 stays set until a reset. The overrun case fills all sixteen entries before the extra character arrives, then pops every entry to confirm the discarded byte never entered the queue.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
   localparam int unsigned CHAR_W = 8;

   // status word bit positions (decoded by host software)
   localparam int unsigned ST_DR   = 0;
   localparam int unsigned ST_OE   = 1;
   localparam int unsigned ST_PE   = 2;
   localparam int unsigned ST_FE   = 3;
   localparam int unsigned ST_BI   = 4;
   localparam int unsigned ST_THRE = 5;
   localparam int unsigned ST_TEMT = 6;
   localparam int unsigned ST_QERR = 7;

   typedef struct packed {
      logic              any_err;  // counted in aggregate, even if tags masked
      logic              brk;
      logic              ferr;
      logic              perr;
      logic [CHAR_W-1:0] data;
   } rx_ent_t;

   localparam int unsigned RX_ENT_W = $bits(rx_ent_t);
endpackage

// File: rtl/lsr_queue.sv
module lsr_queue #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fifo_mode,
   input  logic         push,
   input  logic [W-1:0] push_val,
   input  logic         pop_req,
   input  logic         flush,
   output logic [W-1:0] head,
   output logic         has_data,
   output logic         last_one,
   output logic         push_ok,
   output logic         pop_ok
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lsr_queue: DEPTH must be a power of two, at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("lsr_queue: W must be positive");
   end

   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          at_cap;
   logic [W-1:0]  slot_w [DEPTH];

   assign has_data = (cnt_q != '0);
   assign last_one = (cnt_q == CW'(1));
   assign at_cap   = fifo_mode ? (cnt_q == CW'(DEPTH)) : has_data;
   assign pop_ok   = pop_req & has_data & ~flush;
   assign push_ok  = push & ~flush & (~at_cap | pop_ok);
   assign head     = slot_w[rp_q];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (push_ok && wp_q == AW'(g))
            slot_q <= push_val;
      end
      assign slot_w[g] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + AW'(1);
         if (pop_ok)  rp_q <= rp_q + AW'(1);
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      end
   end
endmodule

// File: rtl/lsr_rx_flags.sv
module lsr_rx_flags #(
   parameter int unsigned DEPTH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_ok,
   input  logic push_err,
   input  logic pop_ok,
   input  logic pop_err,
   input  logic flush,
   input  logic overrun,
   input  logic lsr_rd,
   input  logic has_data,
   output logic oe,
   output logic hide_pf,
   output logic qerr,
   output logic first_done
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [CW-1:0] err_cnt_q;
   logic          lock_q, oe_q, hide_q, first_q;

   assign qerr       = lock_q | (err_cnt_q != '0);
   assign oe         = oe_q;
   assign hide_pf    = hide_q;
   assign first_done = first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_cnt_q <= '0;
         lock_q    <= 1'b0;
         oe_q      <= 1'b0;
         hide_q    <= 1'b0;
         first_q   <= 1'b0;
      end else begin
         if (flush)
            err_cnt_q <= '0;
         else
            err_cnt_q <= err_cnt_q + CW'(push_ok & push_err) - CW'(pop_ok & pop_err);

         if (flush && qerr) lock_q <= 1'b1;

         if (overrun)     oe_q <= 1'b1;
         else if (lsr_rd) oe_q <= 1'b0;

         if (flush || pop_ok)         hide_q <= 1'b0;
         else if (lsr_rd && has_data) hide_q <= 1'b1;

         if (push_ok) first_q <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
   import lsr_pkg::*;
#(
   parameter int unsigned RX_DEPTH = 16,
   parameter int unsigned TX_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_mode,
   input  logic              parity_en,
   input  logic              lsi_en,
   input  logic              thre_en,
   input  logic              rx_stb,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              rx_brk,
   input  logic              rx_pop,
   input  logic              rx_flush,
   output logic [CHAR_W-1:0] rx_head,
   input  logic              lsr_rd,
   output logic [7:0]        lsr,
   input  logic              tx_wr,
   input  logic [CHAR_W-1:0] tx_data,
   input  logic              tx_flush,
   input  logic              tx_take,
   input  logic              tx_busy,
   output logic              tx_avail,
   output logic [CHAR_W-1:0] tx_head,
   output logic              irq_ls,
   output logic              irq_thre
);
   rx_ent_t new_ent, head_ent;
   logic [RX_ENT_W-1:0] head_vec;
   logic rx_has, rx_last, rx_push_ok, rx_pop_ok, rx_overrun;
   logic oe, hide_pf, qerr, first_done;
   logic perr_g;

   assign perr_g = rx_perr & parity_en;

   always_comb begin
      new_ent.data    = rx_data;
      new_ent.any_err = perr_g | rx_ferr | rx_brk;
      // the first character after reset keeps its detailed tags cleared
      new_ent.perr    = perr_g  & first_done;
      new_ent.ferr    = rx_ferr & first_done;
      new_ent.brk     = rx_brk  & first_done;
   end

   lsr_queue #(.DEPTH(RX_DEPTH), .W(RX_ENT_W)) i_rxq (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_mode(fifo_mode),
      .push     (rx_stb),
      .push_val (new_ent),
      .pop_req  (rx_pop),
      .flush    (rx_flush),
      .head     (head_vec),
      .has_data (rx_has),
      .last_one (rx_last),
      .push_ok  (rx_push_ok),
      .pop_ok   (rx_pop_ok)
   );

   assign head_ent   = rx_ent_t'(head_vec);
   assign rx_head    = head_ent.data;
   assign rx_overrun = rx_stb & ~rx_flush & ~rx_push_ok;

   lsr_rx_flags #(.DEPTH(RX_DEPTH)) i_rxf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_ok   (rx_push_ok),
      .push_err  (new_ent.any_err),
      .pop_ok    (rx_pop_ok),
      .pop_err   (head_ent.any_err),
      .flush     (rx_flush),
      .overrun   (rx_overrun),
      .lsr_rd    (lsr_rd),
      .has_data  (rx_has),
      .oe        (oe),
      .hide_pf   (hide_pf),
      .qerr      (qerr),
      .first_done(first_done)
   );

   // transmit side
   logic tx_has, tx_last, tx_wr_ok, tx_take_ok, drained;
   logic thre_q, irq_thre_q;

   lsr_queue #(.DEPTH(TX_DEPTH), .W(CHAR_W)) i_txq (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_mode(fifo_mode),
      .push     (tx_wr),
      .push_val (tx_data),
      .pop_req  (tx_take),
      .flush    (tx_flush),
      .head     (tx_head),
      .has_data (tx_has),
      .last_one (tx_last),
      .push_ok  (tx_wr_ok),
      .pop_ok   (tx_take_ok)
   );

   assign tx_avail = tx_has;
   assign drained  = tx_take_ok & tx_last & ~tx_wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thre_q     <= 1'b0;
         irq_thre_q <= 1'b0;
      end else begin
         if (drained)       thre_q <= 1'b1;
         else if (tx_wr_ok) thre_q <= 1'b0;

         if (drained && !thre_q && thre_en)      irq_thre_q <= 1'b1;
         else if (lsr_rd || tx_wr_ok || !thre_en) irq_thre_q <= 1'b0;
      end
   end

   always_comb begin
      lsr          = '0;
      lsr[ST_DR]   = rx_has;
      lsr[ST_OE]   = oe;
      lsr[ST_PE]   = rx_has & head_ent.perr & ~hide_pf;
      lsr[ST_FE]   = rx_has & head_ent.ferr & ~hide_pf;
      lsr[ST_BI]   = rx_has & head_ent.brk;
      lsr[ST_THRE] = thre_q;
      lsr[ST_TEMT] = thre_q & ~tx_busy;
      lsr[ST_QERR] = qerr;
   end

   assign irq_ls   = lsi_en & (|lsr[ST_BI:ST_OE]);
   assign irq_thre = irq_thre_q;
endmodule

// File: rtl/lsr_checker.sv
module lsr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] lsr,
   input logic       irq_ls,
   input logic       irq_thre,
   input logic       lsi_en,
   input logic       tx_busy,
   input logic       rx_flush,
   input logic       tx_flush,
   input logic       rx_stb,
   input logic       lsr_rd
);
   p_tags_need_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lsr[0] |-> lsr[4:2] == 3'b000);

   p_tag_sets_qerr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|lsr[4:2]) |-> lsr[7]);

   p_oe_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !rx_stb) |=> !lsr[1]);

   p_flush_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr[7] && rx_flush) |=> lsr[7]);

   p_flush_no_thre_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!lsr[5] && tx_flush) |=> !lsr[5]);

   p_temt_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lsr[6] |-> (lsr[5] && !tx_busy));

   p_irq_ls_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ls |-> (lsi_en && (|lsr[4:1])));

   p_irq_thre_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
      irq_thre |-> lsr[5]);
endmodule

bind uart_line_status lsr_checker i_lsr_checker (.*);

// File: tb/test_uart_line_status.sv
module test_uart_line_status;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_mode, parity_en, lsi_en, thre_en;
   logic       rx_stb, rx_perr, rx_ferr, rx_brk, rx_pop, rx_flush;
   logic [7:0] rx_data, rx_head;
   logic       lsr_rd;
   logic [7:0] lsr;
   logic       tx_wr, tx_flush, tx_take, tx_busy, tx_avail;
   logic [7:0] tx_data, tx_head;
   logic       irq_ls, irq_thre;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_line_status i_uart_line_status (.*);

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      fifo_mode = 1'b1; parity_en = 1'b1; lsi_en = 1'b0; thre_en = 1'b0;
      rx_stb = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0; rx_pop = 0; rx_flush = 0;
      rx_data = '0; lsr_rd = 0; tx_wr = 0; tx_flush = 0; tx_take = 0; tx_busy = 0;
      tx_data = '0;
   endtask

   task automatic rx_char(input logic [7:0] d, input logic p, input logic f, input logic b);
      @(negedge clk);
      rx_stb = 1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
      @(negedge clk);
      rx_stb = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
   endtask

   task automatic rx_take(output logic [7:0] d);
      @(negedge clk);
      d = rx_head;
      rx_pop = 1;
      @(negedge clk);
      rx_pop = 0;
   endtask

   task automatic read_lsr(output logic [7:0] v);
      @(negedge clk);
      v = lsr;
      lsr_rd = 1;
      @(negedge clk);
      lsr_rd = 0;
   endtask

   task automatic pulse_rx_flush();
      @(negedge clk); rx_flush = 1;
      @(negedge clk); rx_flush = 0;
   endtask

   task automatic do_reset(input bit prime);
      logic [7:0] d;
      idle_inputs();
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      if (prime) begin
         rx_char(8'h00, 0, 0, 0);
         rx_take(d);
      end
   endtask

   task automatic t_reset_r1();
      do_reset(0);
      check("R1", "status after reset", lsr, 8'h00);
      check("R1", "irq_ls after reset", irq_ls, 0);
      check("R1", "irq_thre after reset", irq_thre, 0);
   endtask

   task automatic t_first_char_r9();
      logic [7:0] d;
      do_reset(0);
      rx_char(8'h5A, 0, 1, 1);
      check("R9", "first char qerr", lsr[7], 1);
      check("R9", "first char tags hidden", lsr[4:2], 3'b000);
      check("R2", "data ready", lsr[0], 1);
      rx_take(d);
      check("R2", "first char data", d, 8'h5A);
      check("R7", "qerr falls after pop", lsr, 8'h00);
   endtask

   task automatic t_head_tags_r3();
      logic [7:0] d;
      do_reset(1);
      lsi_en = 1;
      parity_en = 0;
      rx_char(8'hB0, 1, 0, 0);
      parity_en = 1;
      rx_char(8'hC1, 1, 0, 0);
      rx_char(8'hD2, 0, 1, 0);
      rx_char(8'hE3, 0, 0, 1);
      rx_char(8'hF4, 0, 0, 0);
      check("R3", "gated parity head tags", lsr[4:2], 3'b000);
      check("R7", "qerr with tagged chars queued", lsr[7], 1);
      check("R12", "irq_ls low with clean head", irq_ls, 0);
      rx_take(d);
      check("R2", "order 1", d, 8'hB0);
      check("R3", "parity tag at head", lsr[4:2], 3'b001);
      check("R12", "irq_ls on parity", irq_ls, 1);
      lsi_en = 0;
      #1 check("R12", "irq_ls masked", irq_ls, 0);
      lsi_en = 1;
      rx_take(d);
      check("R2", "order 2", d, 8'hC1);
      check("R3", "framing tag at head", lsr[4:2], 3'b010);
      rx_take(d);
      check("R2", "order 3", d, 8'hD2);
      check("R3", "break tag at head", lsr[4:2], 3'b100);
      rx_take(d);
      check("R2", "order 4", d, 8'hE3);
      check("R7", "qerr clear when no tags left", lsr[7], 0);
      check("R12", "irq_ls low again", irq_ls, 0);
      rx_take(d);
      check("R2", "order 5", d, 8'hF4);
      check("R2", "data ready low when empty", lsr[0], 0);
   endtask

   task automatic t_read_clear_r4();
      logic [7:0] v, d;
      do_reset(1);
      rx_char(8'h11, 1, 0, 0);
      rx_char(8'h22, 0, 1, 1);
      read_lsr(v);
      check("R4", "read returns parity", v[2], 1);
      check("R4", "parity hidden after read", lsr[2], 0);
      rx_take(d);
      check("R4", "new head framing shown", lsr[3], 1);
      read_lsr(v);
      check("R4", "framing hidden after read", lsr[3], 0);
      check("R4", "break kept after read", lsr[4], 1);
   endtask

   task automatic t_overrun_fifo_r5();
      logic [7:0] v, d;
      do_reset(1);
      for (int i = 0; i < 16; i++) rx_char(8'(8'h40 + i), 0, 0, 0);
      check("R5", "no overrun at exactly full", lsr[1], 0);
      rx_char(8'hEE, 0, 0, 0);
      check("R5", "overrun when full", lsr[1], 1);
      read_lsr(v);
      check("R5", "read returns overrun", v[1], 1);
      check("R5", "overrun cleared by read", lsr[1], 0);
      for (int i = 0; i < 16; i++) begin
         rx_take(d);
         check("R5", "contents preserved", d, 8'(8'h40 + i));
      end
      check("R5", "overrunning char discarded", lsr[0], 0);
   endtask

   task automatic t_overrun_single_r6();
      logic [7:0] d;
      do_reset(1);
      fifo_mode = 0;
      rx_char(8'h31, 0, 0, 0);
      check("R6", "no overrun with one char", lsr[1], 0);
      rx_char(8'h32, 0, 0, 0);
      check("R6", "overrun on second char", lsr[1], 1);
      rx_take(d);
      check("R6", "first char kept", d, 8'h31);
      check("R6", "buffer empty after pop", lsr[0], 0);
   endtask

   task automatic t_lock_r8();
      logic [7:0] d;
      do_reset(1);
      rx_char(8'h77, 0, 1, 0);
      check("R8", "qerr before flush", lsr[7], 1);
      pulse_rx_flush();
      check("R8", "queue empty after flush", lsr[0], 0);
      check("R8", "qerr locked after flush", lsr[7], 1);
      rx_char(8'h12, 0, 0, 0);
      rx_take(d);
      check("R8", "qerr stays locked", lsr[7], 1);
      do_reset(0);
      check("R8", "reset releases lock", lsr[7], 0);
      rx_char(8'h01, 0, 0, 0);
      pulse_rx_flush();
      check("R8", "clean flush does not lock", lsr[7], 0);
   endtask

   task automatic t_transmit_r10();
      do_reset(1);
      thre_en = 1;
      @(negedge clk); tx_wr = 1; tx_data = 8'hA1;
      @(negedge clk); tx_wr = 0;
      @(negedge clk); tx_flush = 1;
      @(negedge clk); tx_flush = 0;
      check("R10", "flush does not set holding empty", lsr[5], 0);
      check("R13", "no irq after flush", irq_thre, 0);
      @(negedge clk); tx_wr = 1; tx_data = 8'hA2;
      @(negedge clk); tx_data = 8'hA3;
      @(negedge clk); tx_wr = 0;
      check("R10", "head is first written", tx_head, 8'hA2);
      tx_busy = 1;
      @(negedge clk); tx_take = 1;
      @(negedge clk); tx_take = 0;
      check("R10", "not empty with one left", lsr[5], 0);
      check("R10", "head advances", tx_head, 8'hA3);
      @(negedge clk); tx_take = 1;
      @(negedge clk); tx_take = 0;
      check("R10", "holding empty after drain", lsr[5], 1);
      check("R10", "queue empty", tx_avail, 0);
      check("R11", "temt low while shifter busy", lsr[6], 0);
      check("R13", "irq on holding empty rise", irq_thre, 1);
      tx_busy = 0;
      #1 check("R11", "temt high when shifter idle", lsr[6], 1);
      @(negedge clk); lsr_rd = 1;
      @(negedge clk); lsr_rd = 0;
      check("R13", "irq cleared by status read", irq_thre, 0);
      check("R10", "read keeps holding empty", lsr[5], 1);
      @(negedge clk); tx_wr = 1; tx_data = 8'hA4;
      @(negedge clk); tx_wr = 0;
      check("R10", "write clears holding empty", lsr[5], 0);
      check("R11", "temt clears on write", lsr[6], 0);
      thre_en = 0;
      @(negedge clk); tx_take = 1;
      @(negedge clk); tx_take = 0;
      check("R13", "no irq when disabled", irq_thre, 0);
      check("R10", "holding empty set again", lsr[5], 1);
   endtask

   initial begin
      idle_inputs();
      t_reset_r1();
      t_first_char_r9();
      t_head_tags_r3();
      t_read_clear_r4();
      t_overrun_fifo_r5();
      t_overrun_single_r6();
      t_lock_r8();
      t_transmit_r10();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule